// File: doc/BRIEF.md
# 64-Source Vectored Interrupt Controller

This block collects 64 interrupt request lines and presents them to a processor as two outputs: a normal interrupt line and a fast interrupt line. Each source has a byte-wide control register. The byte turns the source on or off, selects level or edge sensing, and names a destination. Sources set to edge sensing latch each event into a status bit. Software clears a status bit by writing a one to it.

For each of the two outputs, a vector register returns the number of the pending source that currently wins. The winner is the lowest-numbered source under fixed priority. Under rotating priority, the search begins just above the source that was returned last. A handler reads the vector, services that source, and clears or masks it.

All registers sit behind a small synchronous read/write port. The port has 32-bit data and byte enables. Read data appears one cycle after the request.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, both outputs are low and every status bit is 0. Every control byte reads 0, which means disabled, level sensed and routed to the normal line. Both vector registers read 0x0000003F.
- R2: The control byte of source s sits at byte address 0x40+s. The word at 0x40+4n carries sources 4n..4n+3 in byte lanes 0..3. A write changes only the lanes whose byte enable is set, and a read returns all four bytes.
- R3: Control bit 3 enables the source. With control bits 5 and 6 both clear, the source is level sensed. A high input on an enabled, level-sensed source makes it pending, and its output rises one clock edge later. The output falls again once the input is low.
- R4: With control bit 5 set, a low-to-high input transition latches status bit s. Status bit s is bit s%32 of the word at 0x80 (sources 0-31) or 0x84 (sources 32-63). The latched bit stays set after the input falls, and it makes an enabled source pending.
- R5: With control bit 6 set, a high-to-low transition latches the status bit, and a rising transition does not.
- R6: An edge event latches its status bit even while the source is disabled. Enabling the source later makes it pending.
- R7: Writing a 1 to a status bit clears that bit. Writing a 0 leaves the bit unchanged.
- R8: Control bits [2:0] give the destination. Code 0 feeds the normal line, code 1 feeds the fast line, and codes 2 to 7 feed neither output.
- R9: The vector registers sit at 0x20 (normal line) and 0x24 (fast line). Bits [5:0] hold the winning source number, and bit 6 reads back the rotate setting. Under fixed priority, the lowest-numbered pending source wins, and repeated reads return the same source.
- R10: When no source is pending for a line, its vector reads 63. A genuine pending source 63 is told apart from this by bit 31 of the word at 0x84.
- R11: Writing 1 to bit 6 of a vector register turns on rotating priority for that line. Every read that returns a real pending source records that source. Under rotation, the next search starts at the recorded number plus one, wrapping from 63 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| src_in | input | 64 | Interrupt request inputs |
| irq_out | output | 1 | Normal interrupt line, registered |
| fiq_out | output | 1 | Fast interrupt line, registered |

## Verification
A scoreboard queues the expected value of every register read and compares it one cycle later. The bench drives several sources at once and reads the normal-line vector several times in rotating mode. A design that starts the search at the recorded source instead of the one after it would return that source again instead of moving on, and a design that forgets to wrap would never come back to source 7. Edge tests pulse inputs while the source is disabled and use falling-edge sources. A design that latches only enabled sources, or that latches on the wrong edge, shows the wrong status word. Source 63 is raised on purpose, so that a real winner 63 must be separated from the idle value only through the status word. Writes with zero data bits and partial byte enables catch status bits cleared by a zero and control lanes written without their enable.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // control byte fields
  localparam int CTL_EN_BIT   = 3;
  localparam int CTL_RISE_BIT = 5;
  localparam int CTL_FALL_BIT = 6;
  localparam int DEST_W       = 3;
  localparam logic [DEST_W-1:0] DEST_NORMAL = 3'd0;
  localparam logic [DEST_W-1:0] DEST_FAST   = 3'd1;
  // vector register rotate bit
  localparam int ROT_BIT = 6;
  // byte offsets of register groups
  localparam int OFS_VEC_NORMAL = 'h20;
  localparam int OFS_VEC_FAST   = 'h24;
  localparam int OFS_CTL        = 'h40;
  localparam int OFS_STAT       = 'h80;
  typedef logic [7:0] ctl_byte_t;
endpackage

// File: rtl/intc_edge.sv
module intc_edge #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src_in,
  input  logic [N-1:0] rise_sel,
  input  logic [N-1:0] fall_sel,
  input  logic [N-1:0] clr,
  output logic [N-1:0] src_dly,
  output logic [N-1:0] stat
);
  logic [N-1:0] rise_evt, fall_evt;

  assign rise_evt = src_in & ~src_dly & rise_sel;
  assign fall_evt = ~src_in & src_dly & fall_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_dly <= '0;
      stat    <= '0;
    end else begin
      src_dly <= src_in;
      // a new event wins over a clear in the same cycle
      stat    <= (stat & ~clr) | rise_evt | fall_evt;
    end
  end
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     pend,
  input  logic             rot_en,
  input  logic             take,
  output logic [IDX_W-1:0] win,
  output logic             any
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(N - 1);

  logic [IDX_W-1:0] last_q, base, sel;
  logic             hit;

  always_comb begin
    int idx;
    base = '0;
    if (rot_en) base = (last_q == TOP_IDX) ? '0 : last_q + 1'b1;
    sel = '0;
    hit = 1'b0;
    for (int off = 0; off < N; off++) begin
      idx = int'(base) + off;
      if (idx >= N) idx = idx - N;
      if (!hit && pend[idx]) begin
        hit = 1'b1;
        sel = IDX_W'(idx);
      end
    end
  end

  assign win = hit ? sel : TOP_IDX;
  assign any = hit;

  always_ff @(posedge clk) begin
    if (rst)              last_q <= TOP_IDX;
    else if (take && hit) last_q <= sel;
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_en,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W/8-1:0]   bus_be,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [NUM_SRC-1:0]    src_in,
  output logic                  irq_out,
  output logic                  fiq_out
);
  localparam int IDX_W      = $clog2(NUM_SRC);
  localparam int LANES      = DATA_W / 8;
  localparam int LANE_W     = $clog2(LANES);
  localparam int STAT_WORDS = NUM_SRC / DATA_W;
  localparam int WIDX_W     = ADDR_W - LANE_W;

  // ---------------- address decode ----------------
  logic            wr, rd;
  logic [ADDR_W-1:0] ctl_off, stat_off;
  logic [WIDX_W-1:0] ctl_word, stat_word;
  logic            ctl_hit, stat_hit, vn_hit, vf_hit;

  assign wr        = bus_en & bus_we;
  assign rd        = bus_en & ~bus_we;
  assign ctl_off   = bus_addr - ADDR_W'(OFS_CTL);
  assign stat_off  = bus_addr - ADDR_W'(OFS_STAT);
  assign ctl_word  = ctl_off[ADDR_W-1:LANE_W];
  assign stat_word = stat_off[ADDR_W-1:LANE_W];
  assign ctl_hit   = (int'(bus_addr) >= OFS_CTL) && (int'(bus_addr) < OFS_CTL + NUM_SRC);
  assign stat_hit  = (int'(bus_addr) >= OFS_STAT) &&
                     (int'(bus_addr) < OFS_STAT + STAT_WORDS * LANES);
  assign vn_hit    = (bus_addr == ADDR_W'(OFS_VEC_NORMAL));
  assign vf_hit    = (bus_addr == ADDR_W'(OFS_VEC_FAST));

  // ---------------- per-source configuration ----------------
  ctl_byte_t           ctl_q [NUM_SRC];
  logic [NUM_SRC-1:0]  src_en, rise_sel, fall_sel, lvl_sel, stat_clr;
  logic [NUM_SRC-1:0]  to_normal, to_fast, active;
  logic [NUM_SRC-1:0]  pend_normal, pend_fast;
  logic [NUM_SRC-1:0]  src_dly, edge_stat;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam logic [WIDX_W-1:0] CW = WIDX_W'(g / LANES);
    localparam logic [WIDX_W-1:0] SW = WIDX_W'(g / DATA_W);
    localparam int LN = g % LANES;
    localparam int SB = g % DATA_W;

    always_ff @(posedge clk) begin
      if (rst)
        ctl_q[g] <= '0;
      else if (wr && ctl_hit && ctl_word == CW && bus_be[LN])
        ctl_q[g] <= bus_wdata[8*LN +: 8];
    end

    assign src_en[g]    = ctl_q[g][CTL_EN_BIT];
    assign rise_sel[g]  = ctl_q[g][CTL_RISE_BIT];
    assign fall_sel[g]  = ctl_q[g][CTL_FALL_BIT];
    assign lvl_sel[g]   = ~rise_sel[g] & ~fall_sel[g];
    assign to_normal[g] = (ctl_q[g][DEST_W-1:0] == DEST_NORMAL);
    assign to_fast[g]   = (ctl_q[g][DEST_W-1:0] == DEST_FAST);
    assign stat_clr[g]  = wr && stat_hit && stat_word == SW &&
                          bus_be[SB/8] && bus_wdata[SB];
    assign active[g]    = src_en[g] & (lvl_sel[g] ? src_in[g] : edge_stat[g]);
    assign pend_normal[g] = active[g] & to_normal[g];
    assign pend_fast[g]   = active[g] & to_fast[g];
  end

  // ---------------- edge latching ----------------
  intc_edge #(.N(NUM_SRC)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .src_in   (src_in),
    .rise_sel (rise_sel),
    .fall_sel (fall_sel),
    .clr      (stat_clr),
    .src_dly  (src_dly),
    .stat     (edge_stat)
  );

  // ---------------- priority per output ----------------
  logic             rot_normal, rot_fast;
  logic [IDX_W-1:0] win_normal, win_fast;
  logic             irq_any, fiq_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      rot_normal <= 1'b0;
      rot_fast   <= 1'b0;
    end else if (wr && bus_be[0]) begin
      if (vn_hit) rot_normal <= bus_wdata[ROT_BIT];
      if (vf_hit) rot_fast   <= bus_wdata[ROT_BIT];
    end
  end

  intc_prio #(.N(NUM_SRC), .IDX_W(IDX_W)) u_prio_normal (
    .clk    (clk),
    .rst    (rst),
    .pend   (pend_normal),
    .rot_en (rot_normal),
    .take   (rd && vn_hit),
    .win    (win_normal),
    .any    (irq_any)
  );

  intc_prio #(.N(NUM_SRC), .IDX_W(IDX_W)) u_prio_fast (
    .clk    (clk),
    .rst    (rst),
    .pend   (pend_fast),
    .rot_en (rot_fast),
    .take   (rd && vf_hit),
    .win    (win_fast),
    .any    (fiq_any)
  );

  // ---------------- read path ----------------
  logic [DATA_W-1:0] rd_word;

  always_comb begin
    int base_idx;
    rd_word  = '0;
    base_idx = int'(ctl_word) * LANES;
    if (vn_hit) begin
      rd_word[IDX_W-1:0] = win_normal;
      rd_word[ROT_BIT]   = rot_normal;
    end else if (vf_hit) begin
      rd_word[IDX_W-1:0] = win_fast;
      rd_word[ROT_BIT]   = rot_fast;
    end else if (ctl_hit) begin
      for (int l = 0; l < LANES; l++)
        if (base_idx + l < NUM_SRC) rd_word[8*l +: 8] = ctl_q[base_idx + l];
    end else if (stat_hit) begin
      for (int w = 0; w < STAT_WORDS; w++)
        if (stat_word == WIDX_W'(w)) rd_word = edge_stat[w*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
      fiq_out   <= 1'b0;
    end else begin
      bus_rdata <= rd ? rd_word : '0;
      irq_out   <= |pend_normal;
      fiq_out   <= |pend_fast;
    end
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int NUM_SRC = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_en,
  input logic               bus_we,
  input logic [7:0]         bus_addr,
  input logic [3:0]         bus_be,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic [NUM_SRC-1:0] src_in,
  input logic [NUM_SRC-1:0] src_dly,
  input logic [NUM_SRC-1:0] edge_stat,
  input logic [NUM_SRC-1:0] src_en,
  input logic               irq_any,
  input logic               irq_out,
  input logic               fiq_out
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk) rst |=> (!irq_out && !fiq_out));

  // R4
  stat_needs_edge_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((edge_stat & ~$past(edge_stat) & ~($past(src_in) ^ $past(src_dly))) == '0));

  // R7
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_we && bus_addr == 8'h80 && bus_be == 4'hF &&
     bus_wdata == 32'hFFFF_FFFF && src_in[31:0] == src_dly[31:0])
    |=> (edge_stat[31:0] == 32'h0));

  // R3
  all_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (src_en == '0) |=> (!irq_out && !fiq_out));

  // R10
  idle_vector_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !bus_we && bus_addr == 8'h20 && !irq_any) |=> (bus_rdata[5:0] == 6'h3F));
endmodule

bind irq_vector_ctrl intc_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .src_in    (src_in),
  .src_dly   (src_dly),
  .edge_stat (edge_stat),
  .src_en    (src_en),
  .irq_any   (irq_any),
  .irq_out   (irq_out),
  .fiq_out   (fiq_out)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] src = '0;
  logic        irq_out, fiq_out;

  int checks = 0, errors = 0;
  logic rd_seen = 1'b0;
  bit   done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_in(src), .irq_out(irq_out), .fiq_out(fiq_out));

  // monitor: read data is valid the cycle after the request
  always @(posedge clk) rd_seen <= bus_en && !bus_we;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic set_ctl(input int s, input logic [7:0] v);
    wr(8'h40 + 8'(s & ~3), 32'(v) << (8 * (s % 4)), 4'b0001 << (s % 4));
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic pin(input string t, input logic act, input logic e);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", t, act, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    pin("R1 irq_out", irq_out, 1'b0);
    pin("R1 fiq_out", fiq_out, 1'b0);
    rd(8'h20, 32'h3F, "R1 normal vector");
    rd(8'h24, 32'h3F, "R1 fast vector");
    rd(8'h40, 32'h0, "R1 ctl word 0");
    rd(8'h7C, 32'h0, "R1 ctl word 15");
    rd(8'h80, 32'h0, "R1 status low");

    // R2 byte-lane writes
    wr(8'h44, 32'h1122_3344, 4'b0101);
    rd(8'h44, 32'h0022_0044, "R2 lane select");
    wr(8'h44, 32'h0, 4'hF);
    rd(8'h44, 32'h0, "R2 cleared");

    // R3 level source 5 to normal line
    set_ctl(5, 8'h08);
    src[5] = 1'b1;
    idle(2);
    pin("R3 irq high", irq_out, 1'b1);
    pin("R3 fiq low", fiq_out, 1'b0);
    rd(8'h20, 32'h05, "R3 vector 5");
    src[5] = 1'b0;
    idle(2);
    pin("R3 irq dropped", irq_out, 1'b0);
    rd(8'h20, 32'h3F, "R3 vector idle");

    // R8 routing
    set_ctl(5, 8'h09);
    src[5] = 1'b1;
    idle(2);
    pin("R8 fast line high", fiq_out, 1'b1);
    pin("R8 normal line low", irq_out, 1'b0);
    rd(8'h24, 32'h05, "R8 fast vector 5");
    set_ctl(5, 8'h0B);
    idle(2);
    pin("R8 dest3 irq low", irq_out, 1'b0);
    pin("R8 dest3 fiq low", fiq_out, 1'b0);
    src[5] = 1'b0;
    set_ctl(5, 8'h00);

    // R4 rising edge on source 40
    set_ctl(40, 8'h28);
    src[40] = 1'b1;
    idle(1);
    src[40] = 1'b0;
    idle(2);
    pin("R4 irq from latch", irq_out, 1'b1);
    rd(8'h84, 32'h0000_0100, "R4 status bit 40");
    rd(8'h20, 32'h28, "R4 vector 40");
    // R7 write-one-to-clear
    wr(8'h84, 32'h0, 4'hF);
    rd(8'h84, 32'h0000_0100, "R7 zero write keeps bit");
    wr(8'h84, 32'h0000_0100, 4'hF);
    rd(8'h84, 32'h0, "R7 one write clears bit");
    idle(1);
    pin("R7 irq low after clear", irq_out, 1'b0);
    set_ctl(40, 8'h00);

    // R5 falling edge on source 2
    set_ctl(2, 8'h48);
    src[2] = 1'b1;
    idle(2);
    rd(8'h80, 32'h0, "R5 rise ignored");
    pin("R5 irq low on rise", irq_out, 1'b0);
    src[2] = 1'b0;
    idle(2);
    rd(8'h80, 32'h4, "R5 fall latched");
    pin("R5 irq high on fall", irq_out, 1'b1);
    wr(8'h80, 32'h4, 4'hF);
    set_ctl(2, 8'h00);
    idle(2);

    // R6 latch while disabled, source 10
    set_ctl(10, 8'h20);
    src[10] = 1'b1;
    idle(1);
    src[10] = 1'b0;
    idle(2);
    rd(8'h80, 32'h400, "R6 latched while disabled");
    pin("R6 irq low while disabled", irq_out, 1'b0);
    set_ctl(10, 8'h28);
    idle(2);
    pin("R6 irq high once enabled", irq_out, 1'b1);
    wr(8'h80, 32'h400, 4'hF);
    set_ctl(10, 8'h00);
    idle(2);

    // R9 fixed priority with sources 7, 20, 50
    set_ctl(7, 8'h08);
    set_ctl(20, 8'h08);
    set_ctl(50, 8'h08);
    src[7] = 1'b1; src[20] = 1'b1; src[50] = 1'b1;
    idle(1);
    rd(8'h20, 32'h07, "R9 lowest wins");
    rd(8'h20, 32'h07, "R9 fixed repeats");

    // R11 rotating priority
    wr(8'h20, 32'h40, 4'b0001);
    rd(8'h20, 32'h54, "R11 after 7 comes 20");
    rd(8'h20, 32'h72, "R11 after 20 comes 50");
    rd(8'h20, 32'h47, "R11 wraps to 7");
    rd(8'h20, 32'h54, "R11 continues to 20");
    rd(8'h24, 32'h3F, "R11 fast line untouched");
    src[7] = 1'b0; src[20] = 1'b0; src[50] = 1'b0;
    set_ctl(7, 8'h00);
    set_ctl(20, 8'h00);
    set_ctl(50, 8'h00);
    wr(8'h20, 32'h0, 4'b0001);

    // R10 idle vs real source 63
    set_ctl(63, 8'h28);
    rd(8'h20, 32'h3F, "R10 idle reads 63");
    rd(8'h84, 32'h0, "R10 idle status bit31 clear");
    src[63] = 1'b1;
    idle(1);
    src[63] = 1'b0;
    idle(1);
    rd(8'h20, 32'h3F, "R10 real 63 vector");
    rd(8'h84, 32'h8000_0000, "R10 real 63 status bit31");
    pin("R10 irq high for 63", irq_out, 1'b1);
    wr(8'h84, 32'h8000_0000, 4'b1000);
    rd(8'h84, 32'h0, "R10 cleared");

    idle(3);
    if (exp_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule